// File: doc/BRIEF.md
# CAN Receive Identifier Acceptance Filter

This block decides, for every received CAN frame, which of a bank of programmable message objects takes it. When the frame decoder presents an identifier with a strobe, the filter compares it against every object at once. Both 11-bit (base) and 29-bit (extended) identifiers are handled. It returns a one-cycle pulse carrying the number of the winning object and the frame's length code, limited to eight bytes. A frame that no object accepts produces no pulse.

Objects 1 to 14 share one global mask. The highest object, number 15 by default, can use a mask of its own, so it can collect a wide band of identifiers that the others reject. That object also has a buffered receive mode, which makes it a receiver whatever its direction bit says. Software programs identifiers, control bits and both masks through a simple write port. Each write touches exactly one register.

Top module: `can_accept_filter`

## Requirements
- R1: After reset no object is valid, both masks are all ones, and `match_valid`, `match_idx` and `match_dlc` are 0. A frame sent before any object is programmed gives no pulse.
- R2: For an extended frame (`rx_ide`=1), an object whose mask bits are all ones accepts only an identifier equal to its stored 29-bit identifier in every bit.
- R3: For a base frame (`rx_ide`=0), only identifier bits 28..18 are compared. Bits 17..0 of the frame and of the object play no part.
- R4: A mask bit at 0 makes that identifier bit don't-care, so identifiers that differ only in masked bits are accepted.
- R5: Objects 1..14 use the global mask, written with `cfg_sel`=2. The last object uses its own mask, written with `cfg_sel`=3.
- R6: An object takes part only when its control word (`cfg_sel`=1) has valid bit 0 set, receive bit 1 set (1 = receive, 0 = transmit), and extended bit 2 equal to the frame's `rx_ide`.
- R7: When several objects accept a frame, the lowest-numbered one wins, so the last object wins only if objects 1..14 all reject the frame.
- R8: The result appears on the clock edge after the edge that samples `rx_id_valid`. It is a single-cycle `match_valid` pulse with the 1-based object number on `match_idx`. `match_idx` is 0 whenever no pulse is present.
- R9: `match_dlc` carries `rx_dlc` unchanged when it is 8 or less, and 8 when it is larger.
- R10: An identifier write (`cfg_sel`=0, identifier in `cfg_wdata[28:0]`) or a control write changes only the object named by `cfg_obj`. A `cfg_obj` of 0 or above the object count changes nothing.
- R11: Control bit 3 (buffered mode) takes effect on the last object only. There it makes the object receive even when its receive bit is 0. On other objects the bit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Register select: 0 identifier, 1 control, 2 global mask, 3 last-object mask |
| cfg_obj | input | 4 | Target object number, 1-based |
| cfg_wdata | input | 29 | Write data |
| rx_id_valid | input | 1 | Received identifier strobe |
| rx_id | input | 29 | Received identifier, base identifiers in bits 28..18 |
| rx_ide | input | 1 | Frame format: 1 extended, 0 base |
| rx_dlc | input | 4 | Received data length code |
| match_valid | output | 1 | Acceptance pulse |
| match_idx | output | 4 | Winning object number, 0 when idle |
| match_dlc | output | 4 | Length code limited to 8 |

## Verification
The bench uses the default parameters: 15 objects, a separate mask for the last object, and a 4-bit length code limited to 8. With these values, object 15 runs on its own mask path and competes in priority with object 14 under the global mask. The buffered-mode branch and the length limit at the edges 8 and 9 are also reachable. Random rounds reprogram all fifteen objects and both masks. Each round then sends identifiers that lie a few bit flips away from the stored ones, which exercises the masked compare, format mismatches and priority ties across the whole index range.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;

   localparam int unsigned CAN_ID_W  = 29;
   localparam int unsigned CAN_STD_W = 11;

   typedef enum logic [1:0] {
      SEL_ID    = 2'd0,
      SEL_CTRL  = 2'd1,
      SEL_GMASK = 2'd2,
      SEL_LMASK = 2'd3
   } cfg_sel_e;

   // control word layout follows write data bits 3..0
   typedef struct packed {
      logic buf_mode;
      logic ext;
      logic rx;
      logic valid;
   } obj_ctrl_t;

endpackage

// File: rtl/can_filt_bank.sv
module can_filt_bank
   import can_filt_pkg::*;
#(
   parameter int unsigned NUM_OBJ = 15,
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned ID_W    = CAN_ID_W
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_we,
   input  logic [1:0]                    cfg_sel,
   input  logic [IDX_W-1:0]              cfg_obj,
   input  logic [ID_W-1:0]               cfg_wdata,
   output logic [NUM_OBJ-1:0][ID_W-1:0]  obj_id,
   output obj_ctrl_t [NUM_OBJ-1:0]       obj_ctrl,
   output logic [ID_W-1:0]               gmask,
   output logic [ID_W-1:0]               lmask
);

   for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
      logic hit_addr;
      assign hit_addr = cfg_we && (cfg_obj == IDX_W'(g + 1));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            obj_id[g]   <= '0;
            obj_ctrl[g] <= '0;
         end else if (hit_addr) begin
            if (cfg_sel == SEL_ID) begin
               obj_id[g] <= cfg_wdata;
            end else if (cfg_sel == SEL_CTRL) begin
               obj_ctrl[g].valid    <= cfg_wdata[0];
               obj_ctrl[g].rx       <= cfg_wdata[1];
               obj_ctrl[g].ext      <= cfg_wdata[2];
               obj_ctrl[g].buf_mode <= (g == NUM_OBJ - 1) ? cfg_wdata[3] : 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gmask <= '1;
         lmask <= '1;
      end else if (cfg_we) begin
         if (cfg_sel == SEL_GMASK) gmask <= cfg_wdata;
         if (cfg_sel == SEL_LMASK) lmask <= cfg_wdata;
      end
   end

endmodule

// File: rtl/can_filt_match.sv
module can_filt_match
   import can_filt_pkg::*;
#(
   parameter int unsigned NUM_OBJ       = 15,
   parameter int unsigned ID_W          = CAN_ID_W,
   parameter int unsigned STD_W         = CAN_STD_W,
   parameter bit          LAST_OWN_MASK = 1'b1
) (
   input  logic [ID_W-1:0]               rx_id,
   input  logic                          rx_ide,
   input  logic [NUM_OBJ-1:0][ID_W-1:0]  obj_id,
   input  obj_ctrl_t [NUM_OBJ-1:0]       obj_ctrl,
   input  logic [ID_W-1:0]               gmask,
   input  logic [ID_W-1:0]               lmask,
   output logic [NUM_OBJ-1:0]            hit
);

   localparam logic [ID_W-1:0] STD_SPAN = {{STD_W{1'b1}}, {(ID_W - STD_W){1'b0}}};

   for (genvar g = 0; g < NUM_OBJ; g++) begin : g_cmp
      logic [ID_W-1:0] mask_src;
      logic [ID_W-1:0] mask_eff;
      logic            takes_part;

      if ((g == NUM_OBJ - 1) && LAST_OWN_MASK) begin : g_own
         assign mask_src = lmask;
      end else begin : g_glob
         assign mask_src = gmask;
      end

      assign mask_eff   = rx_ide ? mask_src : (mask_src & STD_SPAN);
      assign takes_part = obj_ctrl[g].valid
                        && (obj_ctrl[g].rx || obj_ctrl[g].buf_mode)
                        && (obj_ctrl[g].ext == rx_ide);
      assign hit[g]     = takes_part && (((rx_id ^ obj_id[g]) & mask_eff) == '0);
   end

endmodule

// File: rtl/can_filt_prio.sv
module can_filt_prio #(
   parameter int unsigned NUM_OBJ = 15,
   parameter int unsigned IDX_W   = 4
) (
   input  logic [NUM_OBJ-1:0] hit,
   output logic               any_hit,
   output logic [IDX_W-1:0]   win_idx
);

   always_comb begin
      win_idx = '0;
      for (int k = NUM_OBJ - 1; k >= 0; k--) begin
         if (hit[k]) win_idx = IDX_W'(k + 1);
      end
   end

   assign any_hit = |hit;

endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
   import can_filt_pkg::*;
#(
   parameter int unsigned  NUM_OBJ       = 15,
   parameter int unsigned  DLC_W         = 4,
   parameter int unsigned  MAX_DLC       = 8,
   parameter bit           LAST_OWN_MASK = 1'b1,
   localparam int unsigned IDX_W         = $clog2(NUM_OBJ + 1),
   localparam int unsigned ID_W          = CAN_ID_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_sel,
   input  logic [IDX_W-1:0] cfg_obj,
   input  logic [ID_W-1:0]  cfg_wdata,
   input  logic             rx_id_valid,
   input  logic [ID_W-1:0]  rx_id,
   input  logic             rx_ide,
   input  logic [DLC_W-1:0] rx_dlc,
   output logic             match_valid,
   output logic [IDX_W-1:0] match_idx,
   output logic [DLC_W-1:0] match_dlc
);

   if (NUM_OBJ < 2) begin : g_chk_num
      $error("can_accept_filter: NUM_OBJ must be at least 2");
   end
   if (MAX_DLC >= (1 << DLC_W)) begin : g_chk_dlc
      $error("can_accept_filter: MAX_DLC does not fit in DLC_W bits");
   end

   logic [NUM_OBJ-1:0][ID_W-1:0] obj_id;
   obj_ctrl_t [NUM_OBJ-1:0]      obj_ctrl;
   logic [ID_W-1:0]              gmask;
   logic [ID_W-1:0]              lmask;
   logic [NUM_OBJ-1:0]           hit;
   logic                         any_hit;
   logic [IDX_W-1:0]             win_idx;
   logic [DLC_W-1:0]             dlc_lim;

   can_filt_bank #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W), .ID_W(ID_W)) bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_sel  (cfg_sel),
      .cfg_obj  (cfg_obj),
      .cfg_wdata(cfg_wdata),
      .obj_id   (obj_id),
      .obj_ctrl (obj_ctrl),
      .gmask    (gmask),
      .lmask    (lmask)
   );

   can_filt_match #(
      .NUM_OBJ(NUM_OBJ), .ID_W(ID_W), .STD_W(CAN_STD_W), .LAST_OWN_MASK(LAST_OWN_MASK)
   ) match_i (
      .rx_id   (rx_id),
      .rx_ide  (rx_ide),
      .obj_id  (obj_id),
      .obj_ctrl(obj_ctrl),
      .gmask   (gmask),
      .lmask   (lmask),
      .hit     (hit)
   );

   can_filt_prio #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W)) prio_i (
      .hit    (hit),
      .any_hit(any_hit),
      .win_idx(win_idx)
   );

   assign dlc_lim = (rx_dlc > DLC_W'(MAX_DLC)) ? DLC_W'(MAX_DLC) : rx_dlc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         match_valid <= 1'b0;
         match_idx   <= '0;
         match_dlc   <= '0;
      end else if (rx_id_valid && any_hit) begin
         match_valid <= 1'b1;
         match_idx   <= win_idx;
         match_dlc   <= dlc_lim;
      end else begin
         match_valid <= 1'b0;
         match_idx   <= '0;
         match_dlc   <= '0;
      end
   end

endmodule

// File: rtl/can_accept_filter_chk.sv
module can_accept_filter_chk #(
   parameter int unsigned NUM_OBJ = 15,
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned DLC_W   = 4,
   parameter int unsigned MAX_DLC = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_id_valid,
   input logic [DLC_W-1:0] rx_dlc,
   input logic             match_valid,
   input logic [IDX_W-1:0] match_idx,
   input logic [DLC_W-1:0] match_dlc
);

   a_r8_pulse_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      match_valid |-> $past(rx_id_valid));

   a_r8_idle_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !match_valid |-> (match_idx == '0));

   a_r7_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      match_valid |-> (match_idx != '0 && int'(match_idx) <= NUM_OBJ));

   a_r9_dlc_capped: assert property (@(posedge clk) disable iff (!rst_n)
      match_valid |-> (int'(match_dlc) <= MAX_DLC));

   a_r9_dlc_passed: assert property (@(posedge clk) disable iff (!rst_n)
      (match_valid && int'($past(rx_dlc)) <= MAX_DLC) |-> (match_dlc == $past(rx_dlc)));

endmodule

bind can_accept_filter can_accept_filter_chk #(
   .NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W), .DLC_W(DLC_W), .MAX_DLC(MAX_DLC)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_id_valid(rx_id_valid),
   .rx_dlc     (rx_dlc),
   .match_valid(match_valid),
   .match_idx  (match_idx),
   .match_dlc  (match_dlc)
);

// File: tb/can_accept_filter_tb.sv
module can_accept_filter_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam logic [28:0] ALL1 = '1;
   localparam logic [28:0] STDM = {11'h7FF, 18'h0};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [3:0]  cfg_obj = '0;
   logic [28:0] cfg_wdata = '0;
   logic        rx_id_valid = 1'b0;
   logic [28:0] rx_id = '0;
   logic        rx_ide = 1'b0;
   logic [3:0]  rx_dlc = '0;
   logic        match_valid;
   logic [3:0]  match_idx;
   logic [3:0]  match_dlc;

   int n_chk = 0;
   int n_fail = 0;

   logic [28:0] m_id [1:15];
   bit          m_v [1:15];
   bit          m_rx [1:15];
   bit          m_ext [1:15];
   bit          m_buf;
   logic [28:0] m_gmask;
   logic [28:0] m_lmask;

   always #(CLK_PERIOD / 2) clk = ~clk;

   can_accept_filter dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_obj(cfg_obj),
      .cfg_wdata(cfg_wdata), .rx_id_valid(rx_id_valid), .rx_id(rx_id), .rx_ide(rx_ide),
      .rx_dlc(rx_dlc), .match_valid(match_valid), .match_idx(match_idx), .match_dlc(match_dlc)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_idx(logic [28:0] id, bit ide);
      for (int k = 1; k <= 15; k++) begin
         logic [28:0] m;
         bit part;
         m = (k == 15) ? m_lmask : m_gmask;
         if (!ide) m = m & STDM;
         part = m_v[k] && (m_rx[k] || (k == 15 && m_buf)) && (m_ext[k] == ide);
         if (part && ((id ^ m_id[k]) & m) == '0) return k;
      end
      return 0;
   endfunction

   task automatic cfg_write(input logic [1:0] sel, input int obj, input logic [28:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_obj = 4'(obj); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (sel == 2'd2) m_gmask = d;
      else if (sel == 2'd3) m_lmask = d;
      else if (obj >= 1 && obj <= 15) begin
         if (sel == 2'd0) m_id[obj] = d;
         else begin
            m_v[obj] = d[0]; m_rx[obj] = d[1]; m_ext[obj] = d[2];
            if (obj == 15) m_buf = d[3];
         end
      end
   endtask

   task automatic send(input logic [28:0] id, input bit ide, input int dlc, input string req);
      int e;
      int ed;
      e  = exp_idx(id, ide);
      ed = (dlc > 8) ? 8 : dlc;
      @(negedge clk);
      rx_id_valid = 1'b1; rx_id = id; rx_ide = ide; rx_dlc = 4'(dlc);
      @(negedge clk);
      chk(match_valid == (e != 0), req, "match_valid", int'(match_valid), int'(e != 0));
      chk(int'(match_idx) == e, req, "match_idx", int'(match_idx), e);
      if (e != 0) chk(int'(match_dlc) == ed, req, "match_dlc", int'(match_dlc), ed);
      rx_id_valid = 1'b0;
      @(negedge clk);
      chk(match_valid == 1'b0, "R8", "pulse length", int'(match_valid), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [28:0] A, B, C;
      void'($urandom(32'd4711));
      for (int k = 1; k <= 15; k++) begin
         m_id[k] = '0; m_v[k] = 0; m_rx[k] = 0; m_ext[k] = 0;
      end
      m_buf = 0; m_gmask = ALL1; m_lmask = ALL1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state and empty bank
      chk(match_valid == 1'b0 && match_idx == '0 && match_dlc == '0, "R1", "reset outputs",
          int'(match_valid), 0);
      send(29'h0, 1'b1, 4, "R1");
      send(29'h0, 1'b0, 4, "R1");

      // R2: exact extended match
      A = 29'h0ABCDE1;
      cfg_write(2'd0, 1, A);
      cfg_write(2'd1, 1, 29'h7);
      send(A, 1'b1, 5, "R2");
      send(A ^ 29'h100000, 1'b1, 5, "R2");
      send(A ^ 29'h1, 1'b1, 5, "R2");

      // R3: base frames compare bits 28..18 only
      cfg_write(2'd0, 2, {11'h155, 18'h0});
      cfg_write(2'd1, 2, 29'h3);
      send({11'h155, 18'h2AAAA}, 1'b0, 2, "R3");
      send({11'h154, 18'h0}, 1'b0, 2, "R3");

      // R4: cleared mask bits are don't-care
      cfg_write(2'd2, 0, ~29'hF);
      send(A ^ 29'h5, 1'b1, 1, "R4");
      send(A ^ 29'h10, 1'b1, 1, "R4");

      // R5: last object uses its own mask
      B = 29'h1234560;
      cfg_write(2'd0, 15, B);
      cfg_write(2'd1, 15, 29'h7);
      send(B ^ 29'h3, 1'b1, 0, "R5");
      cfg_write(2'd3, 0, ~29'hFF);
      send(B ^ 29'h3, 1'b1, 0, "R5");
      C = 29'h0F0F0F0;
      cfg_write(2'd0, 14, C);
      cfg_write(2'd1, 14, 29'h7);
      send(C ^ 29'h3, 1'b1, 0, "R5");
      send(C ^ 29'h30, 1'b1, 0, "R5");

      // R6: participation conditions
      cfg_write(2'd0, 3, 29'h1111110);
      cfg_write(2'd1, 3, 29'h6);
      send(29'h1111110, 1'b1, 3, "R6");
      cfg_write(2'd0, 4, 29'h0222220);
      cfg_write(2'd1, 4, 29'h5);
      send(29'h0222220, 1'b1, 3, "R6");
      cfg_write(2'd0, 5, {11'h2F0, 18'h0});
      cfg_write(2'd1, 5, 29'h3);
      send({11'h2F0, 18'h0}, 1'b1, 3, "R6");
      send({11'h2F0, 18'h0}, 1'b0, 3, "R6");

      // R7: lowest number wins
      cfg_write(2'd0, 7, 29'h0333330);
      cfg_write(2'd1, 7, 29'h7);
      cfg_write(2'd0, 9, 29'h0333330);
      cfg_write(2'd1, 9, 29'h7);
      send(29'h0333330, 1'b1, 6, "R7");
      cfg_write(2'd0, 15, C);
      send(C, 1'b1, 6, "R7");

      // R11: buffered mode on the last object
      cfg_write(2'd0, 15, B);
      cfg_write(2'd1, 15, 29'hD);
      send(B, 1'b1, 7, "R11");
      cfg_write(2'd1, 15, 29'h5);
      send(B, 1'b1, 7, "R11");
      cfg_write(2'd0, 6, 29'h0444440);
      cfg_write(2'd1, 6, 29'hD);
      send(29'h0444440, 1'b1, 7, "R11");

      // R9: length code limit
      send(A, 1'b1, 15, "R9");
      send(A, 1'b1, 9, "R9");
      send(A, 1'b1, 8, "R9");
      send(A, 1'b1, 3, "R9");

      // R10: writes touch only the named object
      cfg_write(2'd0, 0, 29'h0555550);
      cfg_write(2'd1, 0, 29'h7);
      send(29'h0555550, 1'b1, 2, "R10");
      cfg_write(2'd0, 8, A);
      cfg_write(2'd1, 8, 29'h7);
      send(A, 1'b1, 2, "R10");
      send({11'h155, 18'h1}, 1'b0, 2, "R10");

      // random rounds against the bench model (R2..R7, R9)
      for (int r = 0; r < 6; r++) begin
         cfg_write(2'd2, 0, 29'($urandom | $urandom | $urandom));
         cfg_write(2'd3, 0, 29'($urandom | $urandom));
         for (int k = 1; k <= 15; k++) begin
            cfg_write(2'd0, k, 29'($urandom));
            cfg_write(2'd1, k, 29'($urandom % 16));
         end
         for (int f = 0; f < 40; f++) begin
            int k;
            bit ide;
            k = 1 + int'($urandom % 15);
            ide = ($urandom % 4 == 0) ? !m_ext[k] : m_ext[k];
            send(m_id[k] ^ 29'($urandom & $urandom & $urandom), ide, int'($urandom % 16), "R7");
         end
      end

      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule